// File: doc/BRIEF.md
# Biphase Mark Sampling Decoder

The decoder turns a biphase-mark encoded line back into data bits. The line arrives already synchronized, and the block looks at it once per receive tick. A tick is a one-cycle enable that comes from a local timebase. That timebase runs independently of the transmitter and may drift against it. The block keeps the last settled line level. While it hunts for the start of a cell, it compares each ticked sample with that stored level, and the first sample that differs marks a cell boundary.

From that boundary the block counts a programmable number of ticks, the decision distance, and then looks at the line a second time. If the level has moved since the boundary, a mark transition happened inside the cell and the bit is 1; otherwise it is 0. The decision sample becomes the new stored level and hunting starts again. The distance must lie past the mid-cell transition and before the next cell boundary. Typical settings are 23 ticks for a 32-tick cell with a 16-tick mark, 11 for 16/8 and 10 for 18/5.

Top module: `bmd_decoder`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `bit_vld` and `bit_out` are 0 and the stored line level is 0, so a first ticked `line_smp` of 1 is taken as a cell boundary.
- R2: While hunting, a tick whose `line_smp` equals the stored level produces no strobe and starts no measurement.
- R3: A tick in the hunt state whose `line_smp` differs from the stored level is a cell boundary. The decision falls on the tick that comes D-1 ticks after it, where D is the effective decision distance.
- R4: The decided bit is 1 when `line_smp` at the decision tick differs from the level stored at the boundary, and 0 when it is equal.
- R5: `bit_vld` is high for exactly one clock cycle, the cycle after the clock edge of the decision tick. `bit_out` changes only together with a strobe and keeps its value between strobes.
- R6: Clock cycles with `tick_en` low change no state: the measurement does not advance and no strobe follows them.
- R7: After a decision the sample taken at the decision tick becomes the stored level, the counter returns to 0 and hunting resumes, so consecutive cells decode back to back.
- R8: A `cfg_dist` of 0 or 1 is treated as a distance of 2, meaning a decision one tick after the boundary.
- R9: With one tick per encoder step and cell/mark/distance settings of 32/16/23, 16/8/11 and 18/5/10, every transmitted bit pattern is recovered in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Receive tick; the line is considered only in cycles where it is high |
| line_smp | input | 1 | Synchronized line level |
| cfg_dist | input | DIST_W | Decision distance in ticks; must stay constant during a measurement |
| bit_out | output | 1 | Last decoded bit |
| bit_vld | output | 1 | One-cycle strobe that marks a new `bit_out` |

## Verification
The assertions check on every cycle that strobes are single-cycle pulses and that `bit_out` moves only with a strobe. They also check that an idle tick enable freezes the counter and suppresses strobes, and that the hunt state always sees a cleared counter. Only the bench scenarios can show the decode itself. These cover the exact tick on which each decision lands relative to the boundary, the recovered values over every 5-bit pattern for three cell geometries, behaviour under gapped ticks, and the clamping of too-small distances.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  typedef enum logic {
    ST_HUNT = 1'b0,
    ST_MEAS = 1'b1
  } bmd_state_e;

  localparam int unsigned BMD_MIN_DIST = 2;

endpackage

// File: rtl/bmd_level_track.sv
module bmd_level_track (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic smp,
  output logic lvl,
  output logic diff
);

  logic lvl_q;
  logic lvl_n;

  always_comb begin
    lvl_n = lvl_q;
    if (load) begin
      lvl_n = smp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_n;
    end
  end

  assign lvl  = lvl_q;
  assign diff = smp ^ lvl_q;

endmodule

// File: rtl/bmd_dist_cnt.sv
module bmd_dist_cnt
  import bmd_pkg::*;
#(
  parameter int unsigned DIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              start,
  input  logic              clr,
  input  logic              inc,
  input  logic [DIST_W-1:0] cfg_dist,
  output logic [DIST_W-1:0] cnt,
  output logic              at_end
);

  localparam logic [DIST_W-1:0] MIN_DIST = DIST_W'(BMD_MIN_DIST);
  localparam logic [DIST_W-1:0] ONE      = DIST_W'(1);

  logic [DIST_W-1:0] cnt_q;
  logic [DIST_W-1:0] cnt_n;
  logic [DIST_W-1:0] dist_eff;

  assign dist_eff = (cfg_dist < MIN_DIST) ? MIN_DIST : cfg_dist;
  assign at_end   = (cnt_q >= (dist_eff - ONE));

  always_comb begin
    cnt_n = cnt_q;
    if (start) begin
      cnt_n = ONE;
    end else if (clr) begin
      cnt_n = '0;
    end else if (inc) begin
      cnt_n = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_n;
    end
  end

  assign cnt = cnt_q;

  AST_CNT_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/bmd_decoder.sv
module bmd_decoder
  import bmd_pkg::*;
#(
  parameter int unsigned DIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              line_smp,
  input  logic [DIST_W-1:0] cfg_dist,
  output logic              bit_out,
  output logic              bit_vld
);

  bmd_state_e        st_q;
  bmd_state_e        st_n;
  logic              lvl;
  logic              diff;
  logic              load;
  logic              start;
  logic              clr;
  logic              inc;
  logic              decide;
  logic              at_end;
  logic [DIST_W-1:0] cnt;
  logic              bit_q;
  logic              bit_n;
  logic              vld_q;

  bmd_level_track i_level (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load),
    .smp  (line_smp),
    .lvl  (lvl),
    .diff (diff)
  );

  bmd_dist_cnt #(.DIST_W(DIST_W)) i_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .start   (start),
    .clr     (clr),
    .inc     (inc),
    .cfg_dist(cfg_dist),
    .cnt     (cnt),
    .at_end  (at_end)
  );

  always_comb begin
    st_n   = st_q;
    load   = 1'b0;
    start  = 1'b0;
    clr    = 1'b0;
    inc    = 1'b0;
    decide = 1'b0;
    if (tick_en) begin
      unique case (st_q)
        ST_HUNT: begin
          if (diff) begin
            st_n  = ST_MEAS;
            load  = 1'b1;
            start = 1'b1;
          end
        end
        ST_MEAS: begin
          if (at_end) begin
            st_n   = ST_HUNT;
            load   = 1'b1;
            clr    = 1'b1;
            decide = 1'b1;
          end else begin
            inc = 1'b1;
          end
        end
        default: st_n = ST_HUNT;
      endcase
    end
  end

  always_comb begin
    bit_n = bit_q;
    if (decide) begin
      bit_n = diff;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_HUNT;
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      bit_q <= bit_n;
      vld_q <= decide;
    end
  end

  assign bit_out = bit_q;
  assign bit_vld = vld_q;

  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld |=> !bit_vld); // R5

  AST_BIT_MOVES_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_out) |-> bit_vld); // R5

  AST_NO_TICK_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> !bit_vld); // R6

  AST_HUNT_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT) |-> (cnt == '0)); // R7

  AST_HUNT_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HUNT && tick_en && line_smp == lvl) |=> (st_q == ST_HUNT && !bit_vld)); // R2

endmodule

// File: tb/test_bmd_decoder.sv
`timescale 1ns/1ps
module test_bmd_decoder;

  localparam int DIST_W = 6;

  logic              clk;
  logic              rst_n;
  logic              tick_en;
  logic              line_smp;
  logic [DIST_W-1:0] cfg_dist;
  logic              bit_out;
  logic              bit_vld;

  int checks;
  int errors;
  int last_bit;

  bmd_decoder #(.DIST_W(DIST_W)) i_bmd_decoder (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .line_smp(line_smp),
    .cfg_dist(cfg_dist),
    .bit_out (bit_out),
    .bit_vld (bit_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n    = 1'b0;
    tick_en  = 1'b0;
    line_smp = 1'b0;
    repeat (3) @(negedge clk);
    chk(bit_vld == 1'b0, "R1 vld in reset", int'(bit_vld), 0);
    chk(bit_out == 1'b0, "R1 bit in reset", int'(bit_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bit_vld == 1'b0, "R1 vld after reset", int'(bit_vld), 0);
    chk(bit_out == 1'b0, "R1 bit after reset", int'(bit_out), 0);
    last_bit = 0;
  endtask

  // One tick with the current line; then gap cycles without a tick (R6).
  task automatic one_tick(input bit exp_vld, input int exp_bit, input int gap, input string req);
    tick_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    tick_en = 1'b0;
    chk(bit_vld == exp_vld, {req, " strobe"}, int'(bit_vld), int'(exp_vld));
    if (exp_vld) begin
      chk(int'(bit_out) == exp_bit, {req, " value"}, int'(bit_out), exp_bit);
      last_bit = exp_bit;
    end else begin
      chk(int'(bit_out) == last_bit, "R5 hold", int'(bit_out), last_bit);
    end
    for (int g = 0; g < gap; g++) begin
      line_smp = ~line_smp; // line moves while no tick: must be ignored
      @(posedge clk);
      @(negedge clk);
      chk(bit_vld == 1'b0, "R6 no strobe without tick", int'(bit_vld), 0);
      line_smp = ~line_smp;
    end
  endtask

  // Encodes nbits cells (bit i = bit (i%5) of i/5, or all zero) and checks decode.
  task automatic run_cells(input int c, input int m, input int s_cfg, input int s_eff,
                           input int gap, input int nbits, input bit zeros, input string req);
    cfg_dist = DIST_W'(s_cfg);
    for (int k = 0; k < 6; k++) one_tick(1'b0, 0, gap, "R2 idle hunt");
    for (int i = 0; i < nbits; i++) begin
      int b;
      b = zeros ? 0 : (((i / 5) >> (i % 5)) & 1);
      for (int t = 0; t < c; t++) begin
        if (t == 0) line_smp = ~line_smp;
        if (t == m && b == 1) line_smp = ~line_smp;
        one_tick(t == s_eff - 1, b, gap, req); // R3 R4 R7
      end
    end
  endtask

  initial begin
    checks   = 0;
    errors   = 0;
    last_bit = 0;
    rst_n    = 1'b0;
    tick_en  = 1'b0;
    line_smp = 1'b0;
    cfg_dist = '0;

    do_reset();
    run_cells(32, 16, 23, 23, 0, 160, 1'b0, "R9 32/16/23 R3 R4");
    do_reset();
    run_cells(16, 8, 11, 11, 0, 160, 1'b0, "R9 16/8/11 R4 R7");
    do_reset();
    run_cells(18, 5, 10, 10, 0, 160, 1'b0, "R9 18/5/10 R3");
    do_reset();
    run_cells(16, 8, 11, 11, 2, 80, 1'b0, "R6 gapped ticks");
    do_reset();
    run_cells(4, 2, 1, 2, 0, 10, 1'b1, "R8 distance 1");
    do_reset();
    run_cells(4, 2, 0, 2, 1, 10, 1'b1, "R8 distance 0");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule